// File: doc/BRIEF.md
# Multi-Ratio Synchronous Clock Divider

This block takes one fast CPU-rate clock and derives from it every slower synchronous clock a multiprocessor board needs: a half-rate memory reference clock, a nominal 66 MHz clock, a nominal 33 MHz clock and an interrupt-controller (APIC) clock. A rate input says whether the CPU clock runs at 133 MHz (1) or at 100 MHz (0).

At the high rate the 66 MHz clock is the CPU clock divided by 2. At the low rate it is divided by 1.5, which uses both clock edges. In both cases its frequency stays near 66.67 MHz. The 33 MHz clock is always that clock divided by 2, so it is the CPU clock divided by 4 at the high rate and by 3 at the low rate.

A strap input is captured once after reset. When the strap is 1, the APIC clock runs at one quarter of the CPU clock. When it is 0, the APIC clock stays near 16.67 MHz: divide-by-8 at the high rate and divide-by-6 at the low rate.

Each time the rate input is seen to change, and on the first clock edge after reset, every divider restarts on the same rising CPU edge. This keeps the rising edges of all outputs lined up with the CPU clock.

Top module: `syncdiv_top`

## Requirements
- R1: While `rst_n` is low, all four output clocks are held at 0.
- R2: `mem_ref` has a period of 4 CPU half-periods and is high for 2 of them, in both rate modes.
- R3: With `rate_hi`=1, `mid_clk` has a period of 4 CPU half-periods and is high for 2.
- R4: With `rate_hi`=0, `mid_clk` has a period of 3 CPU half-periods and is high for 2. Its rising edges therefore fall alternately on rising and falling CPU edges.
- R5: `pci_clk` has a period of 8 half-periods and is high for 4 when `rate_hi`=1. It has a period of 6 half-periods and is high for 3 when `rate_hi`=0.
- R6: With the captured strap equal to 1, `apic_clk` has a period of 8 half-periods and is high for 4, in both rate modes.
- R7: With the captured strap equal to 0, `apic_clk` has a period of 16 half-periods (high 8) when `rate_hi`=1, and 12 half-periods (high 6) when `rate_hi`=0.
- R8: `apic_strap` is captured on the first rising CPU edge after reset is released. Later changes have no effect on `apic_clk` until the next reset.
- R9: A change of `rate_hi` before a rising CPU edge restarts all dividers at that edge. All four outputs are high just after it, and the new ratios apply from then on.
- R10: The first rising CPU edge after reset is released is a restart edge. All four outputs go high just after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Fast CPU-rate input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_hi | input | 1 | 1: 133 MHz input rate, 0: 100 MHz input rate |
| apic_strap | input | 1 | APIC ratio strap, 1: quarter rate, 0: fixed rate |
| mem_ref | output | 1 | Half-rate memory reference clock |
| mid_clk | output | 1 | Nominal 66 MHz clock |
| pci_clk | output | 1 | Nominal 33 MHz clock |
| apic_clk | output | 1 | APIC clock |

## Verification
A wrong divider count shows up at once in the measured edge-to-edge period of the affected output, within one output period of the first rising edge measured. A lost restart or a stale captured rate leaves the outputs out of phase just after the restart edge, which is caught on the very next half-cycle sample. A strap captured at the wrong time, or re-captured later, gives the APIC clock the other fixed period. This is visible within one period of that clock, even though the strap pin is flipped right after the capture edge.

// File: rtl/syncdiv_pkg.sv
`timescale 1ns/1ps
package syncdiv_pkg;

  // Ratios in CPU clock periods for the even, rising-edge-only dividers.
  localparam int RATIO_REF      = 2;
  localparam int RATIO_PCI_HI   = 4;
  localparam int RATIO_APIC_QTR = 4;
  localparam int RATIO_APIC_HI  = 8;
  localparam int RATIO_APIC_LO  = 6;

  // Even divider lanes: 0 = memory reference, 1 = 33 MHz at high rate, 2 = APIC.
  localparam int NUM_EVEN  = 3;
  localparam int LANE_REF  = 0;
  localparam int LANE_PCI  = 1;
  localparam int LANE_APIC = 2;

  function automatic int apic_ratio(input logic rate_hi, input logic quarter);
    if (quarter) return RATIO_APIC_QTR;
    return rate_hi ? RATIO_APIC_HI : RATIO_APIC_LO;
  endfunction

  function automatic int lane_ratio(input int lane, input logic rate_hi, input logic quarter);
    case (lane)
      LANE_REF: return RATIO_REF;
      LANE_PCI: return RATIO_PCI_HI;
      default:  return apic_ratio(rate_hi, quarter);
    endcase
  endfunction

endpackage

// File: rtl/syncdiv_even.sv
`timescale 1ns/1ps
module syncdiv_even #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] ratio,
  output logic             out_clk
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_wrap;

  // Count 0 .. ratio-1; the output is high for the first half of the count.
  always_comb begin
    cnt_wrap = (cnt >= ratio - 1'b1);
    cnt_nxt  = cnt_wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      out_clk <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      out_clk <= 1'b1;
    end else begin
      cnt     <= cnt_nxt;
      out_clk <= (cnt_nxt < (ratio >> 1));
    end
  end

  AST_EVEN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (out_clk && cnt == '0)); // R9

  AST_EVEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (cnt < ratio)); // R2

endmodule

// File: rtl/syncdiv_third.sv
`timescale 1ns/1ps
module syncdiv_third (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic frac_out,
  output logic third_out
);

  logic [1:0] ph;
  logic [1:0] ph_nxt;
  logic       lead_q;
  logic       frac_q;
  logic       third_q;

  // Three-phase counter on rising edges; lead_q is high for phase 0.
  assign ph_nxt = (ph == 2'd2) ? 2'd0 : ph + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= 2'd0;
      lead_q <= 1'b0;
    end else if (restart) begin
      ph     <= 2'd0;
      lead_q <= 1'b1;
    end else begin
      ph     <= ph_nxt;
      lead_q <= (ph_nxt == 2'd0);
    end
  end

  // Falling-edge half: frac_q starts the second short cycle mid-period,
  // third_q stretches lead_q by one half-period for the 50% divide-by-3.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q  <= 1'b0;
      third_q <= 1'b0;
    end else begin
      frac_q  <= (ph == 2'd1);
      third_q <= lead_q;
    end
  end

  assign frac_out  = lead_q | frac_q;
  assign third_out = lead_q | third_q;

  AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_q && !restart) |=> !lead_q); // R4

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (ph != 2'd3)); // R4

  AST_THIRD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    third_q == lead_q); // R5

endmodule

// File: rtl/syncdiv_top.sv
`timescale 1ns/1ps
module syncdiv_top #(
  parameter int CNT_W = 4
) (
  input  logic clk_cpu,
  input  logic rst_n,
  input  logic rate_hi,
  input  logic apic_strap,
  output logic mem_ref,
  output logic mid_clk,
  output logic pci_clk,
  output logic apic_clk
);
  import syncdiv_pkg::*;

  logic armed;
  logic sel_q;
  logic strap_q;
  logic restart;

  logic [CNT_W-1:0] lane_ratio_v [NUM_EVEN];
  logic             lane_out     [NUM_EVEN];
  logic             frac_clk;
  logic             third_clk;

  // First edge after reset, or any observed rate change, restarts all lanes.
  assign restart = !armed || (sel_q != rate_hi);

  always_ff @(posedge clk_cpu or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      sel_q   <= 1'b0;
      strap_q <= 1'b0;
    end else begin
      armed <= 1'b1;
      sel_q <= rate_hi;
      if (!armed) strap_q <= apic_strap;
    end
  end

  for (genvar gi = 0; gi < NUM_EVEN; gi++) begin : g_lane
    assign lane_ratio_v[gi] = CNT_W'(lane_ratio(gi, sel_q, strap_q));
    syncdiv_even #(.CNT_W(CNT_W)) u_even (
      .clk     (clk_cpu),
      .rst_n   (rst_n),
      .restart (restart),
      .ratio   (lane_ratio_v[gi]),
      .out_clk (lane_out[gi])
    );
  end

  syncdiv_third u_third (
    .clk       (clk_cpu),
    .rst_n     (rst_n),
    .restart   (restart),
    .frac_out  (frac_clk),
    .third_out (third_clk)
  );

  assign mem_ref  = lane_out[LANE_REF];
  assign mid_clk  = sel_q ? lane_out[LANE_REF] : frac_clk;
  assign pci_clk  = sel_q ? lane_out[LANE_PCI] : third_clk;
  assign apic_clk = lane_out[LANE_APIC];

  AST_STRAP_HELD: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    armed |=> $stable(strap_q)); // R8

  AST_REF_TOGGLE: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    (armed && !restart) |=> (mem_ref != $past(mem_ref))); // R2

  AST_RESTART_ALIGN: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    restart |=> (mem_ref && mid_clk && pci_clk && apic_clk)); // R9

  AST_RATE_CAPTURE: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    restart |=> (sel_q == $past(rate_hi))); // R9

endmodule

// File: tb/sim_syncdiv_top.sv
`timescale 1ns/1ps
module sim_syncdiv_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;

  logic clk_cpu    = 1'b0;
  logic rst_n      = 1'b0;
  logic rate_hi    = 1'b0;
  logic apic_strap = 1'b0;
  logic mem_ref, mid_clk, pci_clk, apic_clk;

  syncdiv_top u0 (
    .clk_cpu    (clk_cpu),
    .rst_n      (rst_n),
    .rate_hi    (rate_hi),
    .apic_strap (apic_strap),
    .mem_ref    (mem_ref),
    .mid_clk    (mid_clk),
    .pci_clk    (pci_clk),
    .apic_clk   (apic_clk)
  );

  always #HALF clk_cpu = ~clk_cpu;

  typedef struct {
    int    id;
    int    period;
    int    high;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  logic busy   = 1'b0;

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic pick(input int id);
    case (id)
      0:       return mem_ref;
      1:       return mid_clk;
      2:       return pci_clk;
      default: return apic_clk;
    endcase
  endfunction

  // Expected periods and high times, in CPU half-periods.
  function automatic int want_period(input int id, input logic hi, input logic strap);
    case (id)
      0:       return 4;
      1:       return hi ? 4 : 3;
      2:       return hi ? 8 : 6;
      default: return strap ? 8 : (hi ? 16 : 12);
    endcase
  endfunction

  function automatic int want_high(input int id, input logic hi, input logic strap);
    case (id)
      0:       return 2;
      1:       return 2;
      2:       return hi ? 4 : 3;
      default: return want_period(id, hi, strap) / 2;
    endcase
  endfunction

  function automatic string want_tag(input int id, input logic hi, input logic strap);
    case (id)
      0:       return "R2";
      1:       return hi ? "R3" : "R4";
      2:       return "R5";
      default: return strap ? "R6" : "R7";
    endcase
  endfunction

  // Driver side: queue expectations for all outputs, then wait for the monitor.
  task automatic push_all(input logic hi, input logic strap);
    for (int id = 0; id < 4; id++) begin
      exp_t e;
      e.id     = id;
      e.period = want_period(id, hi, strap);
      e.high   = want_high(id, hi, strap);
      e.tag    = want_tag(id, hi, strap);
      sb.push_back(e);
    end
    wait (sb.size() == 0 && !busy);
  endtask

  task automatic check_all_level(input logic lvl, input string tag);
    check(mem_ref  == lvl, tag, "mem_ref level",  int'(mem_ref),  int'(lvl));
    check(mid_clk  == lvl, tag, "mid_clk level",  int'(mid_clk),  int'(lvl));
    check(pci_clk  == lvl, tag, "pci_clk level",  int'(pci_clk),  int'(lvl));
    check(apic_clk == lvl, tag, "apic_clk level", int'(apic_clk), int'(lvl));
  endtask

  task automatic run_cfg(input logic hi, input logic strap);
    @(negedge clk_cpu);
    rst_n      = 1'b0;
    rate_hi    = hi;
    apic_strap = strap;
    repeat (3) @(negedge clk_cpu);
    #1;
    check_all_level(1'b0, "R1");
    @(negedge clk_cpu);
    rst_n = 1'b1;
    @(posedge clk_cpu);
    #1;
    check_all_level(1'b1, "R10");
    apic_strap = ~strap;  // R8: later strap changes must be ignored
    repeat (6) @(posedge clk_cpu);
    push_all(hi, strap);
  endtask

  // Monitor side: pop an expectation and measure rise-fall-rise in half-periods.
  initial begin
    forever begin
      wait (sb.size() > 0);
      busy = 1'b1;
      begin
        exp_t e;
        int   stage;
        int   t0, t1, t2;
        logic prev;
        e = sb.pop_front();
        stage = 0;
        t0 = 0; t1 = 0; t2 = 0;
        @(clk_cpu);
        #1;
        prev = pick(e.id);
        while (stage < 3) begin
          logic v;
          @(clk_cpu);
          #1;
          v = pick(e.id);
          if (v != prev) begin
            int k;
            k = (int'($time) - 1) / HALF;
            if (stage == 0 && v)       begin t0 = k; stage = 1; end
            else if (stage == 1 && !v) begin t1 = k; stage = 2; end
            else if (stage == 2 && v)  begin t2 = k; stage = 3; end
          end
          prev = v;
        end
        check((t2 - t0) == e.period, e.tag, $sformatf("output %0d period", e.id),
              t2 - t0, e.period);
        check((t1 - t0) == e.high, e.tag, $sformatf("output %0d high time", e.id),
              t1 - t0, e.high);
      end
      busy = 1'b0;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    run_cfg(1'b1, 1'b1);
    run_cfg(1'b1, 1'b0);
    run_cfg(1'b0, 1'b1);
    run_cfg(1'b0, 1'b0);

    // R9: rate change without reset, low to high, then back.
    @(negedge clk_cpu);
    rate_hi = 1'b1;
    @(posedge clk_cpu);
    #1;
    check_all_level(1'b1, "R9");
    repeat (4) @(posedge clk_cpu);
    push_all(1'b1, 1'b0);

    @(negedge clk_cpu);
    rate_hi = 1'b0;
    @(posedge clk_cpu);
    #1;
    check_all_level(1'b1, "R9");
    repeat (4) @(posedge clk_cpu);
    push_all(1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule